// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one channel of an interval timer. It has a 16-bit down-counter that runs on the system clock. A gate input enables or triggers the counter, and the block drives a single timer output line. Software first writes a control byte that picks the counting behaviour. It then writes the initial count over the same 8-bit data path, low byte first and high byte second. The channel supports six behaviours:

- a terminal-count delay;
- a retriggerable hardware one-shot;
- a divide-by-N rate generator;
- a square-wave generator;
- a software-started single strobe;
- a gate-started single strobe.

The gate input has two roles, depending on the behaviour. In the level-sensitive behaviours it pauses the count. In the edge-triggered behaviours a rising edge on the gate starts or restarts the count.

In the two periodic behaviours, the first count written after a control byte starts the counter. A count written later only replaces the reload value, which takes effect at the next period boundary or at the next gate restart.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is high and the counter is idle.
- R2: A `wr_ctrl` strobe takes the mode from `din[2:0]`. Codes 0 to 5 select behaviours 0 to 5. Codes 6 and 7 act as codes 2 and 3. The strobe also restarts the byte order at the low byte. From the next clock edge, `out` is low for mode 0 and high for every other mode.
- R3: Two `wr_data` strobes form the count, low byte first and high byte second. The counter loads on the first clock edge after the edge that takes the high byte (the load edge). A count of 0 stands for 65536.
- R4: Mode 0: `out` stays low until N counted edges after the load edge have passed. It then goes high and stays high until a new control byte or a new count is written.
- R5: Mode 1: once a count has been written, a rising `gate` edge drives `out` low for exactly N clocks. A new rising edge during the pulse restarts the full N, and the gate level is otherwise ignored.
- R6: Mode 1: a count written while a pulse is active does not change that pulse. It sets the length of the pulse started by the next trigger.
- R7: Mode 2: with N ≥ 2, `out` is low for one clock in every N. The low clock is the (N−1)-th edge after the load edge, and the pattern repeats every N edges.
- R8: Mode 3: with N ≥ 2, `out` repeats a period of N clocks. Each period is high for ceil(N/2) clocks and then low for floor(N/2) clocks.
- R9: Mode 4: `out` is low for exactly one clock, at the N-th counted edge after the load edge, and then stays high. Writing a new count restarts the sequence.
- R10: Mode 5: `out` is low for exactly one clock, at the N-th edge after a rising `gate` edge. After that rising edge the gate level has no effect.
- R11: In modes 0 and 4, a clock edge with `gate` low is not counted. This delays the result by one clock for each such edge.
- R12: In modes 2 and 3, `gate` low forces `out` high and holds the count. The edge on which `gate` rises again restarts a full period, as the load edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctrl | input | 1 | Control byte strobe; mode taken from `din[2:0]` |
| wr_data | input | 1 | Count byte strobe, low byte then high byte |
| din | input | 8 | Write data |
| gate | input | 1 | Gate level / trigger input |
| out | output | 1 | Registered timer output |

## Verification
- **Control byte:** its effect on `out` is visible just after the edge that captures `wr_ctrl`.
- **Count write:** the count takes effect one edge after the high-byte edge, and a trigger acts on the edge that first sees `gate` high.
- **Output timing:** every change of `out` is due a whole number of edges after that load or trigger edge. The bench numbers those edges and predicts `out` for each edge from closed-form expressions of N and the edge index.
- **Sampling:** the bench drives and samples only on falling clock edges, so each prediction is compared half a period after the edge that produced it.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC_DELAY  = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } pit_mode_e;

  // codes with bit 1 set lose bit 2: 6 -> 2, 7 -> 3
  function automatic pit_mode_e fold_mode(input logic [2:0] code);
    if (code[1]) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction

endpackage

// File: rtl/pit_count_reg.sv
module pit_count_reg #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] din,
  output logic [CNT_W-1:0]  count,
  output logic              load_q
);
  localparam int NB = CNT_W / DATA_W;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;
  localparam int SW = CNT_W - DATA_W;

  logic [PW-1:0] ptr_q;
  logic [SW-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      stage_q <= '0;
      count   <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (wr_ctrl) begin
        ptr_q <= '0;
      end else if (wr_data) begin
        if (ptr_q == PW'(NB - 1)) begin
          count  <= {din, stage_q};
          ptr_q  <= '0;
          load_q <= 1'b1;
        end else begin
          stage_q[int'(ptr_q)*DATA_W +: DATA_W] <= din;
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise
);
  logic g_q;

  always_ff @(posedge clk) begin
    if (rst) g_q <= 1'b1;
    else     g_q <= gate;
  end

  assign rise = gate & ~g_q;
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [2:0]       ctrl_code,
  input  logic             load_q,
  input  logic [CNT_W-1:0] count,
  input  logic             gate,
  input  logic             gate_rise,
  output logic             out_q,
  output pit_mode_e        mode_q
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0] cnt_q, nfull, half_hi, half_lo, reload_val;
  logic          run_q, armed_q, live_q;
  pit_mode_e     new_mode;

  assign nfull      = (count == '0) ? (CW'(1) << CNT_W) : {1'b0, count};
  assign half_hi    = (nfull + CW'(1)) >> 1;
  assign half_lo    = nfull >> 1;
  assign reload_val = (mode_q == M_SQUARE) ? half_hi : nfull;
  assign new_mode   = fold_mode(ctrl_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_TC_DELAY;
      cnt_q   <= '0;
      out_q   <= 1'b1;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      live_q  <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q  <= new_mode;
      out_q   <= (new_mode != M_TC_DELAY);
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      case (mode_q)
        M_TC_DELAY: begin
          if (load_q) begin
            cnt_q <= nfull;
            out_q <= 1'b0;
            run_q <= 1'b1;
          end else if (run_q && gate) begin
            if (cnt_q == CW'(1)) begin
              out_q <= 1'b1;
              run_q <= 1'b0;
            end else cnt_q <= cnt_q - CW'(1);
          end
        end
        M_SW_STROBE: begin
          if (load_q) begin
            cnt_q <= nfull;
            out_q <= 1'b1;
            run_q <= 1'b1;
          end else if (!out_q) begin
            out_q <= 1'b1;
          end else if (run_q && gate) begin
            if (cnt_q == CW'(1)) begin
              out_q <= 1'b0;
              run_q <= 1'b0;
            end else cnt_q <= cnt_q - CW'(1);
          end
        end
        M_ONESHOT, M_HW_STROBE: begin
          if (load_q) armed_q <= 1'b1;
          if (armed_q && gate_rise) begin
            cnt_q <= nfull;
            run_q <= 1'b1;
            out_q <= (mode_q == M_HW_STROBE);
          end else if (mode_q == M_HW_STROBE && !out_q) begin
            out_q <= 1'b1;
          end else if (run_q) begin
            if (cnt_q == CW'(1)) begin
              out_q <= (mode_q == M_ONESHOT);
              run_q <= 1'b0;
            end else cnt_q <= cnt_q - CW'(1);
          end
        end
        M_RATE, M_SQUARE: begin
          if (load_q && !live_q) begin
            live_q <= 1'b1;
            cnt_q  <= reload_val;
            out_q  <= 1'b1;
          end else if (live_q) begin
            if (!gate) begin
              out_q <= 1'b1;
            end else if (gate_rise) begin
              cnt_q <= reload_val;
              out_q <= 1'b1;
            end else if (mode_q == M_RATE) begin
              if (cnt_q == CW'(2)) begin
                out_q <= 1'b0;
                cnt_q <= CW'(1);
              end else if (cnt_q == CW'(1)) begin
                out_q <= 1'b1;
                cnt_q <= reload_val;
              end else cnt_q <= cnt_q - CW'(1);
            end else begin
              if (cnt_q == CW'(1)) begin
                out_q <= ~out_q;
                cnt_q <= out_q ? half_lo : half_hi;
              end else cnt_q <= cnt_q - CW'(1);
            end
          end
        end
        default: begin
          out_q <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] din,
  input  logic              gate,
  output logic              out
);
  logic [CNT_W-1:0] count;
  logic             load_q;
  logic             gate_rise;
  pit_mode_e        mode_q;

  pit_count_reg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_creg (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .din(din), .count(count), .load_q(load_q)
  );

  pit_gate_edge u_gedge (
    .clk(clk), .rst(rst), .gate(gate), .rise(gate_rise)
  );

  pit_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .ctrl_code(din[2:0]),
    .load_q(load_q), .count(count), .gate(gate), .gate_rise(gate_rise),
    .out_q(out), .mode_q(mode_q)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_ctrl,
  input logic [DATA_W-1:0] din,
  input logic              out,
  input logic [2:0]        mode_q,
  input logic              load_q
);
  assert_ctrl_delay_low_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && din[2:0] == 3'd0) |=> !out);

  assert_ctrl_other_high_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && din[2:0] != 3'd0) |=> out);

  assert_delay_holds_high_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd0 && out && !wr_ctrl && !load_q) |=> out);

  assert_rate_single_low_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd2 && !out && !wr_ctrl) |=> out);

  assert_strobe_single_low_R9: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 3'd4 || mode_q == 3'd5) && !out && !wr_ctrl) |=> out);
endmodule

bind pit_channel pit_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .din(din),
  .out(out), .mode_q(mode_q), .load_q(load_q)
);

// File: tb/pit_channel_tb.sv
`timescale 1ns/1ps
module pit_channel_tb;
  logic       clk = 1'b0;
  logic       rst, wr_ctrl, wr_data, gate;
  logic [7:0] din;
  logic       out;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  pit_channel u_dut (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .din(din), .gate(gate), .out(out)
  );

  function automatic bit rate_exp(int n, int k);
    return (k % n) != (n - 1);
  endfunction

  function automatic bit sq_exp(int n, int k);
    return (k % n) < ((n + 1) / 2);
  endfunction

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (out !== exp) begin
      errors++;
      $display("FAIL %s: out=%0b expected %0b", tag, out, exp);
    end
  endtask

  task automatic ctrl(input logic [2:0] code);
    wr_ctrl = 1'b1; din = {5'd0, code};
    @(negedge clk);
    wr_ctrl = 1'b0;
  endtask

  task automatic load(input logic [15:0] n);
    wr_data = 1'b1; din = n[7:0];
    @(negedge clk);
    din = n[15:8];
    @(negedge clk);
    wr_data = 1'b0;
  endtask

  task automatic periodic(input logic [2:0] code, input int n, input string tag);
    gate = 1'b1;
    ctrl(code);
    load(16'(n));
    for (int k = 0; k < 3 * n; k++) begin
      @(negedge clk);
      chk(code[0] ? sq_exp(n, k) : rate_exp(n, k), tag);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: out=%0b expected end of run", out);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_ctrl = 1'b0; wr_data = 1'b0; din = '0; gate = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(1'b1, "R1 reset level");

    // mode 0 plain delay
    gate = 1'b1;
    ctrl(3'd0);
    chk(1'b0, "R2 mode0 control low");
    load(16'd10);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      chk(k >= 10, "R4 delay N=10");
    end

    // stray byte, then control restarts byte order: count 0x0103
    wr_data = 1'b1; din = 8'hFF; @(negedge clk); wr_data = 1'b0;
    ctrl(3'd0);
    load(16'h0103);
    for (int k = 0; k < 262; k++) begin
      @(negedge clk);
      if (k >= 256) chk(k >= 259, "R3 byte order 259");
    end

    // count zero means 65536
    ctrl(3'd0);
    load(16'd0);
    for (int k = 0; k <= 65536; k++) begin
      @(negedge clk);
      if (k == 65535) chk(1'b0, "R3 zero count before end");
      if (k == 65536) chk(1'b1, "R3 zero count at 65536");
    end

    // mode 0 with gate paused for 3 edges
    ctrl(3'd0);
    load(16'd12);
    for (int k = 0; k < 20; k++) begin
      gate = !(k >= 4 && k < 7);
      @(negedge clk);
      chk(k >= 15, "R11 mode0 gate pause");
    end
    gate = 1'b1;

    // mode 4 strobe
    ctrl(3'd4);
    chk(1'b1, "R2 mode4 control high");
    load(16'd7);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(k != 7, "R9 strobe N=7");
    end
    load(16'd6);
    for (int k = 0; k < 13; k++) begin
      gate = !(k >= 2 && k < 5);
      @(negedge clk);
      chk(k != 9, "R11 mode4 gate pause");
    end
    gate = 1'b1;

    // periodic modes, direct and aliased codes
    periodic(3'd2, 5, "R7 rate N=5");
    periodic(3'd6, 4, "R2 alias 6 as rate");
    periodic(3'd3, 6, "R8 square N=6");
    periodic(3'd3, 7, "R8 square N=7");
    periodic(3'd7, 5, "R2 alias 7 as square");

    // mode 2 and 3: gate low forces high, rise restarts
    ctrl(3'd2);
    load(16'd5);
    for (int k = 0; k < 30; k++) begin
      gate = !(k >= 8 && k < 11);
      @(negedge clk);
      if (k < 8)       chk(rate_exp(5, k), "R12 rate before pause");
      else if (k < 11) chk(1'b1, "R12 rate paused high");
      else             chk(rate_exp(5, k - 11), "R12 rate restart");
    end
    ctrl(3'd3);
    load(16'd6);
    for (int k = 0; k < 30; k++) begin
      gate = !(k >= 4 && k < 6);
      @(negedge clk);
      if (k < 4)      chk(sq_exp(6, k), "R12 square before pause");
      else if (k < 6) chk(1'b1, "R12 square paused high");
      else            chk(sq_exp(6, k - 6), "R12 square restart");
    end

    // mode 1 single pulse, gate drops during pulse
    gate = 1'b0;
    ctrl(3'd1);
    load(16'd6);
    for (int k = 0; k < 12; k++) begin
      gate = (k == 2 || k == 3);
      @(negedge clk);
      chk(!(k >= 2 && k < 8), "R5 oneshot N=6");
    end
    // retrigger during pulse
    for (int k = 0; k < 16; k++) begin
      gate = (k >= 2 && k < 4) || (k >= 5);
      @(negedge clk);
      chk(!(k >= 2 && k < 11), "R5 oneshot retrigger");
    end

    // mode 1 count rewrite during pulse
    gate = 1'b0;
    ctrl(3'd1);
    load(16'd10);
    @(negedge clk);
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    chk(1'b0, "R6 pulse starts");
    gate = 1'b0;
    load(16'd4);
    for (int k = 3; k < 13; k++) begin
      @(negedge clk);
      chk(k >= 10, "R6 pulse keeps old count");
    end
    gate = 1'b1;
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      gate = 1'b0;
      chk(j >= 4, "R6 next pulse uses new count");
    end

    // mode 5 strobe after trigger, gate level ignored afterwards
    ctrl(3'd5);
    load(16'd5);
    for (int k = 0; k < 11; k++) begin
      gate = (k == 2);
      @(negedge clk);
      chk(k != 7, "R10 gate-started strobe");
    end

    // constrained random periodic runs
    void'($urandom(32'd2024));
    for (int t = 0; t < 8; t++) begin
      logic [2:0] code;
      int         n;
      code = {$urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, 1'b1, $urandom_range(0, 1) == 1 ? 1'b1 : 1'b0};
      n    = int'($urandom_range(2, 24));
      periodic(code, n, code[0] ? "R8 random square" : "R7 random rate");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule